// File: doc/BRIEF.md
# Receive Byte Queue with Movable Fill Threshold

This block buffers bytes that arrive from a serial bus engine until software reads them from a register port. It is a sixteen-entry, eight-bit first-in first-out store. The engine offers one byte per cycle on a push strobe. Software reaches the queue through four small registers:

- a data register that removes the oldest byte when it is read;
- a fill-level register;
- a threshold register;
- a status register.

The fill level and the threshold are both one less than the byte count they stand for. The receive-threshold event output rises once the stored count reaches the threshold plus one. Software moves the threshold from one chunk of a transfer to the next. For example, it can set the threshold to the number of bytes still expected minus one, so the event fires exactly when the final chunk is complete.

A dedicated clear input empties the queue, drops the sticky overflow indication and returns the threshold to fifteen. The synchronous active-low reset does the same.

Top module: `rxw_fifo_top`

## Requirements
- R1: The queue holds 16 bytes and returns them in arrival order. After 16 accepted pushes and no pops, `full` is 1.
- R2: A read with `reg_addr` = 0 returns the oldest stored byte on `reg_rdata` in the same cycle and removes it at the clock edge.
- R3: A read with `reg_addr` = 1 returns the stored count minus one in bits 3:0, with the upper bits zero. It returns 0 when the queue is empty, and the read has no side effect.
- R4: The threshold register is at `reg_addr` = 2. It is 4 bits wide, reads back in bits 3:0 and is 15 after reset. `rx_event` is 1 whenever the stored count is at least the threshold plus one.
- R5: `rx_event` is recomputed every cycle. Writing a threshold below the current fill raises `rx_event` in the cycle after the write, with no push needed.
- R6: `empty` and `full` reflect the stored count. A read with `reg_addr` = 3 returns bit 0 = empty, bit 1 = full and bit 2 = overflow, with the other bits zero.
- R7: A push while the queue is full and no pop happens in the same cycle is dropped and sets `overflow`. `overflow` stays at 1 until a clear or reset.
- R8: A data read from an empty queue returns 0 and changes neither the contents nor the flags.
- R9: `soft_clr` (or `rst_n` low) empties the queue, sets the threshold to 15 and clears `overflow` at the next edge. It takes priority over a push, pop or write in the same cycle.
- R10: When the queue is full, a push and a pop in the same cycle both take effect: the oldest byte leaves and the new byte is stored.
- R11: Writes with `reg_addr` 0, 1 or 3 change nothing that is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of the queue, threshold and overflow |
| push_vld | input | 1 | Bus engine offers a byte this cycle |
| push_byte | input | 8 | Byte offered by the bus engine |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 fill level, 2 threshold, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds 16 bytes |
| overflow | output | 1 | Sticky: a push was dropped |
| rx_event | output | 1 | Fill count is at or above threshold plus one |

## Verification
Seeded random cycles mix the following operations, with a bias toward pushes so the queue regularly reaches full:
- pushes;
- data reads;
- simultaneous push and read;
- threshold writes;
- writes to read-only addresses;
- occasional clears.

This separates wrong ordering, from byte mismatches, from off-by-one errors in the fill-level and event comparisons. Directed sequences cover the cases random stimulus reaches rarely or cannot observe cleanly:
- filling to exactly 16 and pushing once more, which shows the drop and the sticky overflow;
- a simultaneous push and pop while full;
- reading the empty queue;
- lowering the threshold under the current fill, which shows the event rising with no push;
- a clear that coincides with a push.

// File: rtl/rxw_pkg.sv
// Package: shared constants and register selects for the receive queue.
// Assumes a two-bit register address space.
package rxw_pkg;
    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_LEVEL  = 2'd1,
        SEL_THRESH = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam int STAT_EMPTY_BIT = 0;
    localparam int STAT_FULL_BIT  = 1;
    localparam int STAT_OVF_BIT   = 2;
endpackage

// File: rtl/rxw_store.sv
// Module: byte storage array with one write port and a combinational head read.
// Assumes the controller only asserts wr_en when the slot at wr_idx is free
// and only presents a valid rd_idx while the queue is not empty.
module rxw_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];

    // Write one slot per accepted push.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // Present the slot at the read pointer.
    always_comb begin
        rd_data = cells[rd_idx];
    end
endmodule

// File: rtl/rxw_ctrl.sv
// Module: pointer, count and overflow bookkeeping of the receive queue.
// Assumes push and pop requests are single-cycle strobes. A pop on empty is
// ignored. A push on full is dropped unless a pop happens in the same cycle.
module rxw_ctrl #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          is_empty,
    output logic          is_full,
    output logic          ovf
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IX = PW'(DEPTH - 1);

    logic pop_ok;
    logic clr;

    // Decode which requests are honoured this cycle.
    always_comb begin
        clr      = soft_clr || !rst_n;
        is_empty = (count == '0);
        is_full  = (count == DEPTH_C);
        pop_ok   = pop_req && !is_empty;
        push_ok  = push_req && (!is_full || pop_ok) && !clr;
    end

    // Advance the write pointer on each accepted push.
    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= (wr_ptr == LAST_IX) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Advance the read pointer on each honoured pop.
    always_ff @(posedge clk) begin
        if (clr) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= (rd_ptr == LAST_IX) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track the stored count.
    always_ff @(posedge clk) begin
        if (clr) begin
            count <= '0;
        end else if (push_ok && !pop_ok) begin
            count <= count + 1'b1;
        end else if (pop_ok && !push_ok) begin
            count <= count - 1'b1;
        end
    end

    // Latch a dropped push until cleared.
    always_ff @(posedge clk) begin
        if (clr) begin
            ovf <= 1'b0;
        end else if (push_req && !push_ok) begin
            ovf <= 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req && !pop_req && !soft_clr) |=> (ovf && $stable(count))); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !soft_clr) |=> ovf); // R7
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop_req && !push_req && !soft_clr) |=> ((count == '0) && $stable(rd_ptr))); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> ((count == '0) && !ovf)); // R9
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req && pop_req && !soft_clr) |=> (count == DEPTH_C)); // R10
endmodule

// File: rtl/rxw_regs.sv
// Module: register front of the receive queue: threshold register, read mux,
// pop strobe generation and threshold event comparison.
// Assumes reads are combinational and that side effects land at the clock edge.
module rxw_regs
    import rxw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          pop_req,
    input  logic [DW-1:0] head_data,
    input  logic [CW-1:0] count,
    input  logic          is_empty,
    input  logic          is_full,
    input  logic          ovf,
    output logic          rx_event
);
    localparam logic [PW-1:0] THR_RST = PW'(DEPTH - 1);

    logic [PW-1:0] thresh;
    logic [PW-1:0] level;
    logic [CW-1:0] trip;

    // Hold the zero-based fill threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            thresh <= THR_RST;
        end else if (reg_wr && reg_addr == SEL_THRESH) begin
            thresh <= reg_wdata[PW-1:0];
        end
    end

    // Derive the pop strobe, the zero-based level and the event each cycle.
    always_comb begin
        pop_req  = reg_rd && (reg_addr == SEL_DATA);
        level    = is_empty ? '0 : PW'(count - 1'b1);
        trip     = {1'b0, thresh} + 1'b1;
        rx_event = (count >= trip);
    end

    // Select the read data.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_DATA:   reg_rdata = is_empty ? '0 : head_data;
            SEL_LEVEL:  reg_rdata[PW-1:0] = level;
            SEL_THRESH: reg_rdata[PW-1:0] = thresh;
            SEL_STATUS: begin
                reg_rdata[STAT_EMPTY_BIT] = is_empty;
                reg_rdata[STAT_FULL_BIT]  = is_full;
                reg_rdata[STAT_OVF_BIT]   = ovf;
            end
        endcase
    end

    AST_THRESH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (thresh == THR_RST)); // R9
    AST_THRESH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == SEL_THRESH && !soft_clr) |=> (thresh == $past(reg_wdata[PW-1:0]))); // R4
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && reg_rd && reg_addr == SEL_DATA) |-> (reg_rdata == '0)); // R8
endmodule

// File: rtl/rxw_fifo_top.sv
// Module: receive byte queue with a movable fill threshold, seen from the bus
// engine (push side) and from a small register port (software side).
// Assumes one push and at most one register access per cycle.
module rxw_fifo_top #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          push_vld,
    input  logic [DW-1:0] push_byte,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          empty,
    output logic          full,
    output logic          overflow,
    output logic          rx_event
);
    logic          pop_req;
    logic          push_ok;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic [DW-1:0] head_data;

    rxw_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (wr_ptr),
        .wr_data (push_byte),
        .rd_idx  (rd_ptr),
        .rd_data (head_data)
    );

    rxw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .push_req (push_vld),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .is_empty (empty),
        .is_full  (full),
        .ovf      (overflow)
    );

    rxw_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pop_req   (pop_req),
        .head_data (head_data),
        .count     (count),
        .is_empty  (empty),
        .is_full   (full),
        .ovf       (overflow),
        .rx_event  (rx_event)
    );

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R6
endmodule

// File: tb/test_rxw_fifo_top.sv
module test_rxw_fifo_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       push_vld = 1'b0;
    logic [7:0] push_byte = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       empty, full, overflow, rx_event;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state.
    byte unsigned mq[$];
    int           m_thr = 15;
    bit           m_ovf = 1'b0;

    rxw_fifo_top i_rxw_fifo_top (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .push_vld(push_vld), .push_byte(push_byte),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .empty(empty), .full(full), .overflow(overflow), .rx_event(rx_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return (mq.size() == 0) ? 8'h00 : mq[0];
            2'd1: return (mq.size() == 0) ? 8'h00 : 8'(mq.size() - 1);
            2'd2: return 8'(m_thr);
            default: return {5'b0, m_ovf, mq.size() == DEPTH, mq.size() == 0};
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk({req, " empty"},    {7'b0, empty},    {7'b0, mq.size() == 0});
        chk({req, " full"},     {7'b0, full},     {7'b0, mq.size() == DEPTH});
        chk({req, " overflow"}, {7'b0, overflow}, {7'b0, m_ovf});
        chk({req, " rx_event"}, {7'b0, rx_event}, {7'b0, mq.size() >= m_thr + 1});
    endtask

    // One cycle: drive at negedge, check read data, update model at edge, check flags.
    task automatic step(input string req, input bit p, input logic [7:0] pb,
                        input bit rd, input bit wr, input logic [1:0] a,
                        input logic [7:0] wd, input bit clr);
        bit pop_ok, push_ok;
        push_vld = p; push_byte = pb; reg_rd = rd; reg_wr = wr;
        reg_addr = a; reg_wdata = wd; soft_clr = clr;
        #1;
        if (rd) chk(req, reg_rdata, exp_read(a));
        @(posedge clk);
        if (clr) begin
            mq.delete(); m_thr = 15; m_ovf = 1'b0;
        end else begin
            pop_ok  = rd && a == 2'd0 && mq.size() > 0;
            push_ok = p && (mq.size() < DEPTH || pop_ok);
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(pb);
            if (p && !push_ok) m_ovf = 1'b1;
            if (wr && a == 2'd2) m_thr = int'(wd[3:0]);
        end
        @(negedge clk);
        push_vld = 0; reg_rd = 0; reg_wr = 0; soft_clr = 0;
        chk_flags(req);
    endtask

    task automatic rd_all(input string req);
        for (int k = 0; k < 4; k++) step(req, 0, 0, 1, 0, 2'(k), 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R9 reset");
        rd_all("R4 reset regs");

        // Fill to full, then overflow.
        for (int i = 0; i < DEPTH; i++) step("R1 fill", 1, 8'(8'h40 + i), 0, 0, 0, 0, 0);
        step("R3 level full", 0, 0, 1, 0, 2'd1, 0, 0);
        step("R7 drop on full", 1, 8'hEE, 0, 0, 0, 0, 0);
        step("R6 status", 0, 0, 1, 0, 2'd3, 0, 0);
        step("R10 swap on full", 1, 8'h99, 1, 0, 2'd0, 0, 0);
        // Ignored writes.
        step("R11 write data", 0, 0, 0, 1, 2'd0, 8'hFF, 0);
        step("R11 write level", 0, 0, 0, 1, 2'd1, 8'h00, 0);
        step("R11 write status", 0, 0, 0, 1, 2'd3, 8'h00, 0);
        rd_all("R11 readback");
        // Drain in order.
        for (int i = 0; i < DEPTH; i++) step("R2 drain", 0, 0, 1, 0, 2'd0, 0, 0);
        step("R8 empty read", 0, 0, 1, 0, 2'd0, 0, 0);
        step("R3 level empty", 0, 0, 1, 0, 2'd1, 0, 0);
        step("R7 sticky", 0, 0, 1, 0, 2'd3, 0, 0);
        // Threshold moves.
        for (int i = 0; i < 5; i++) step("R4 fill", 1, 8'(i), 0, 0, 0, 0, 0);
        step("R5 lower thr", 0, 0, 0, 1, 2'd2, 8'h02, 0);
        step("R4 thr at fill", 0, 0, 0, 1, 2'd2, 8'h04, 0);
        step("R4 thr above", 0, 0, 0, 1, 2'd2, 8'h05, 0);
        step("R4 push to trip", 1, 8'h55, 0, 0, 0, 0, 0);
        step("R9 clear with push", 1, 8'h77, 0, 1, 2'd2, 8'h01, 1);
        rd_all("R9 after clear");

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 99);
            logic [7:0] b = 8'($urandom);
            logic [1:0] a = 2'($urandom);
            if (op < 40)      step("R1 rnd push", 1, b, 0, 0, 0, 0, 0);
            else if (op < 65) step("R2 rnd pop", 0, 0, 1, 0, 2'd0, 0, 0);
            else if (op < 75) step("R10 rnd both", 1, b, 1, 0, 2'd0, 0, 0);
            else if (op < 85) step("R3 rnd read", 0, 0, 1, 0, a, 0, 0);
            else if (op < 97) step("R5 rnd write", 0, 0, 0, 1, a, b, 0);
            else              step("R9 rnd clear", $urandom_range(0, 1), b, 0, 0, 0, 0, 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule